// File: doc/BRIEF.md
# Dual Timer/Counter Unit

The block holds two up-counters, each split into a low byte and a high byte that software can read and write on their own. Each counter advances either once per machine cycle (timer use) or once per falling edge on its own external count pin (counter use). A hardware gate can make counting depend on an external gate pin as well as on the software run bit. Two configuration bits per counter select one of four layouts. The first is a 13-bit counter made of a 5-bit prescaler in the low byte feeding the high byte. The second is a full 16-bit cascade. The third is an 8-bit counter in the low byte that reloads from the high byte on every wrap. The fourth is a split layout: counter 0 becomes two independent 8-bit counters, and counter 1 stops.

Each counter has an overflow flag that can serve as an interrupt request. Software can write the flag, and an acknowledge pulse clears it. In the split layout the high byte of counter 0 takes over the run bit and the flag of counter 1. The single-cycle overflow strobe of counter 1 is exported so that a rate generator outside the block can use it. The machine-cycle enable comes from a divide-by-12 of the oscillator outside the block. The register port is a plain single-cycle write strobe with a combinational read, so it has no back-pressure.

Top module: `tc_dual_timer`

## Requirements
- R1: After reset, every register reads 00h, both flags are 0, and the overflow strobe is 0.
- R2: Counter i advances only when its run bit is 1 and either its gate bit is 0 or ext_gate[i] is 1. With the source-select bit 0, it takes one step in each cycle where mc_en is 1.
- R3: Layout 00 is a 13-bit counter. Low byte bits [4:0] form a prescaler, and the high byte steps when the prescaler wraps from 31 to 0. Low byte bits [7:5] hold their value. The flag sets when the whole 13-bit value wraps to 0.
- R4: Layout 01 is a 16-bit counter, with the low byte carrying into the high byte. The flag sets on the wrap from FFFFh to 0000h.
- R5: Layout 10 counts in the low byte only. A step at FFh loads the low byte from the high byte and sets the flag.
- R6: Layout 11 on counter 0 splits it in two. The low byte is an 8-bit counter under the R2 enable rule and sets flag 0 on its wrap. The high byte steps on every mc_en while run bit 1 is set, and sets flag 1 on its wrap.
- R7: Layout 11 on counter 1 holds its bytes and gives no overflow. While counter 0 is in layout 11, counter 1 in any other layout still counts and drives t1_ovf_pulse, but it does not set flag 1.
- R8: With the source-select bit 1, the counter samples ext_cnt[i] once per mc_en cycle. A 1 sample followed by a 0 sample gives one step. Sampling starts from a held 0 after reset.
- R9: Flag bits read at control-register bit 7 (flag 1) and bit 5 (flag 0), and the run bits at bit 6 (run 1) and bit 4 (run 0). A control write stores all four bits. irq_ack[i] clears flag i. An overflow in the same cycle sets the flag, and this overrides both the write and the acknowledge. ovf_flag[i] shows flag i.
- R10: A write to a count byte in the same cycle as a step stores the written value. The other byte still takes its step, and overflow is judged on the values before the write.
- R11: Register addresses are 0 for configuration, 1 for control, 2/3 for the counter 0 low/high bytes and 4/5 for the counter 1 low/high bytes. Addresses 6 and 7 read 00h. Configuration bits run, from bit 3 down to bit 0, gate, source select, layout[1:0] for counter 0. Bits 7 to 4 repeat the same fields for counter 1. Control bits [3:0] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Machine-cycle enable, one pulse per 12 oscillator periods |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| ext_cnt | input | 2 | External count pins, bit i for counter i |
| ext_gate | input | 2 | External gate pins, bit i for counter i |
| irq_ack | input | 2 | Flag clear pulses, bit i for flag i |
| ovf_flag | output | 2 | Overflow flags, bit i is flag i |
| t1_ovf_pulse | output | 1 | One-cycle strobe on each overflow of counter 1 |

## Verification
The bench builds the block with its default 8-bit count bytes and 5-bit prescaler. At these sizes an 8-bit wrap takes a few hundred machine cycles, and random byte writes often place a counter just below a 13-bit or 16-bit wrap. That brings every overflow path within reach in a short run, including overflows that land on a write, an acknowledge or a layout change. Randomly timed layout writes also put counter 0 into and out of the split layout while counter 1 is running, which exercises the change of owner for flag 1.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRESC_W = 5;

  typedef enum logic [1:0] {
    LAY_13     = 2'b00,
    LAY_16     = 2'b01,
    LAY_RELOAD = 2'b10,
    LAY_SPLIT  = 2'b11
  } tc_layout_e;

  typedef struct packed {
    logic       gate;
    logic       src_ext;
    tc_layout_e layout;
  } tc_cfg_t;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tc_pin_sampler.sv
module tc_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic pin,
  output logic fall_tick
);
  logic smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     smp_q <= 1'b0;
    else if (mc_en) smp_q <= pin;
  end

  assign fall_tick = mc_en & smp_q & ~pin;

  // R8: after a counted edge the stored sample is low, so no edge can follow at once
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !fall_tick);
endmodule

// File: rtl/tc_count_unit.sv
module tc_count_unit
  import tc_pkg::*;
#(
  parameter int CNT_W     = BYTE_W,
  parameter int PRE_W     = PRESC_W,
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tc_layout_e       layout,
  input  logic             tick_lo,
  input  logic             tick_hi,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] lo,
  output logic [CNT_W-1:0] hi,
  output logic             ovf_main,
  output logic             ovf_split
);
  localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] P_MAX = {PRE_W{1'b1}};
  localparam logic [PRE_W-1:0] P_ONE = PRE_W'(1);

  logic [CNT_W-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    case (layout)
      LAY_13: begin
        if (tick_lo) begin
          if (lo_q[PRE_W-1:0] == P_MAX) begin
            lo_n[PRE_W-1:0] = '0;
            hi_n            = hi_q + C_ONE;
            ovf_main        = (hi_q == C_MAX);
          end else begin
            lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + P_ONE;
          end
        end
      end
      LAY_16: begin
        if (tick_lo) begin
          lo_n = lo_q + C_ONE;
          if (lo_q == C_MAX) begin
            hi_n     = hi_q + C_ONE;
            ovf_main = (hi_q == C_MAX);
          end
        end
      end
      LAY_RELOAD: begin
        if (tick_lo) begin
          if (lo_q == C_MAX) begin
            lo_n     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo_q + C_ONE;
          end
        end
      end
      default: begin
        if (SPLIT_CAP) begin
          if (tick_lo) begin
            lo_n     = lo_q + C_ONE;
            ovf_main = (lo_q == C_MAX);
          end
          if (tick_hi) begin
            hi_n      = hi_q + C_ONE;
            ovf_split = (hi_q == C_MAX);
          end
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

  // R2: with no step and no write both bytes keep their value
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_lo && !tick_hi && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  // R10: a byte write always lands, whatever the counting does
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));

  // R5: a wrap in reload layout copies the old high byte
  a_r5_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_RELOAD && tick_lo && lo_q == C_MAX && !wr_lo) |=> (lo_q == $past(hi_q)));

  // R4: 16-bit wrap yields zero in both bytes
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAY_16 && ovf_main && !wr_lo && !wr_hi) |=> (lo_q == '0 && hi_q == '0));

  generate
    if (!SPLIT_CAP) begin : g_hold_chk
      // R7: the non-split counter freezes in layout 11
      a_r7_split_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/tc_ctrl_regs.sv
module tc_ctrl_regs
  import tc_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        set_flag,
  input  logic [1:0]        ack,
  output tc_cfg_t           cfg0,
  output tc_cfg_t           cfg1,
  output logic [1:0]        run,
  output logic [1:0]        flag
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wdata[7:0];
  end

  assign cfg0 = tc_cfg_t'(cfg_q[3:0]);
  assign cfg1 = tc_cfg_t'(cfg_q[7:4]);

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ch
      localparam int FLAG_BIT = (i == 1) ? 7 : 5;
      localparam int RUN_BIT  = (i == 1) ? 6 : 4;
      logic run_q, flag_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q  <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          if (wr_ctrl) run_q <= wdata[RUN_BIT];
          if (set_flag[i])  flag_q <= 1'b1;
          else if (ack[i])  flag_q <= 1'b0;
          else if (wr_ctrl) flag_q <= wdata[FLAG_BIT];
        end
      end

      assign run[i]  = run_q;
      assign flag[i] = flag_q;

      // R9: a hardware set beats any clear in the same cycle
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag[i] |=> flag_q);

      // R9: an acknowledge with no overflow leaves the flag clear
      a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[i] && !set_flag[i]) |=> !flag_q);
    end
  endgenerate
endmodule

// File: rtl/tc_dual_timer.sv
module tc_dual_timer
  import tc_pkg::*;
#(
  parameter int CNT_W = BYTE_W,
  parameter int PRE_W = PRESC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_en,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [1:0]       ext_cnt,
  input  logic [1:0]       ext_gate,
  input  logic [1:0]       irq_ack,
  output logic [1:0]       ovf_flag,
  output logic             t1_ovf_pulse
);
  tc_cfg_t          cfg0, cfg1;
  tc_cfg_t          cfg [2];
  logic [1:0]       run, flag, fall, tick, set_flag;
  logic [1:0]       ovf_main, ovf_split;
  logic [CNT_W-1:0] lo [2];
  logic [CNT_W-1:0] hi [2];
  logic             t0_split;

  assign cfg[0]   = cfg0;
  assign cfg[1]   = cfg1;
  assign t0_split = (cfg0.layout == LAY_SPLIT);

  tc_ctrl_regs #(.DATA_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cfg   (reg_wr && reg_addr == A_CFG),
    .wr_ctrl  (reg_wr && reg_addr == A_CTRL),
    .wdata    (reg_wdata),
    .set_flag (set_flag),
    .ack      (irq_ack),
    .cfg0     (cfg0),
    .cfg1     (cfg1),
    .run      (run),
    .flag     (flag)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_tmr
      localparam logic [2:0] LO_ADDR = (g == 0) ? A_LO0 : A_LO1;
      localparam logic [2:0] HI_ADDR = (g == 0) ? A_HI0 : A_HI1;
      logic enable, tick_hi;

      tc_pin_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_en     (mc_en),
        .pin       (ext_cnt[g]),
        .fall_tick (fall[g])
      );

      assign enable  = run[g] & (~cfg[g].gate | ext_gate[g]);
      assign tick[g] = enable & (cfg[g].src_ext ? fall[g] : mc_en);
      assign tick_hi = (g == 0) ? (mc_en & run[1]) : 1'b0;

      tc_count_unit #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SPLIT_CAP(g == 0)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .layout    (cfg[g].layout),
        .tick_lo   (tick[g]),
        .tick_hi   (tick_hi),
        .wr_lo     (reg_wr && reg_addr == LO_ADDR),
        .wr_hi     (reg_wr && reg_addr == HI_ADDR),
        .wdata     (reg_wdata),
        .lo        (lo[g]),
        .hi        (hi[g]),
        .ovf_main  (ovf_main[g]),
        .ovf_split (ovf_split[g])
      );
    end
  endgenerate

  assign set_flag[0]  = ovf_main[0];
  assign set_flag[1]  = t0_split ? ovf_split[0] : ovf_main[1];
  assign ovf_flag     = flag;
  assign t1_ovf_pulse = ovf_main[1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata[7:0] = {cfg1, cfg0};
      A_CTRL:  reg_rdata[7:0] = {flag[1], run[1], flag[0], run[0], 4'b0000};
      A_LO0:   reg_rdata = lo[0];
      A_HI0:   reg_rdata = hi[0];
      A_LO1:   reg_rdata = lo[1];
      A_HI1:   reg_rdata = hi[1];
      default: reg_rdata = '0;
    endcase
  end

  // R7: while counter 0 is split, an overflow of counter 1 alone does not raise flag 1
  a_r7_flag1_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && ovf_main[1] && !ovf_split[0] && !flag[1] && !(reg_wr && reg_addr == A_CTRL))
    |=> !flag[1]);

  // R6: the split high byte raises flag 1
  a_r6_split_hi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && ovf_split[0]) |=> flag[1]);
endmodule

// File: tb/tc_dual_timer_tb_top.sv
module tc_dual_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [1:0] ext_cnt = 2'b00, ext_gate = 2'b00, irq_ack = 2'b00, ovf_flag;
  logic       t1_ovf_pulse;

  int checks = 0, fails = 0;

  // bench model state
  logic [7:0] m_cfg = 8'h00;
  logic [1:0] m_run = 2'b00, m_flag = 2'b00;
  logic [7:0] m_lo [2] = '{8'h00, 8'h00};
  logic [7:0] m_hi [2] = '{8'h00, 8'h00};
  logic [1:0] m_smp = 2'b00;
  logic [7:0] last_rd;

  always #4 clk = ~clk;

  tc_dual_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
    .irq_ack(irq_ack), .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'h0};
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    logic [1:0] md;
    if (a < 3'd2 || a > 3'd5) return "R11";
    md = (a < 3'd4) ? m_cfg[1:0] : m_cfg[5:4];
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return (a < 3'd4) ? "R6" : "R7";
    endcase
  endfunction

  // one layout step expressed as arithmetic on the combined count value
  task automatic advance(input logic [1:0] md, input bit split_ok, input bit tk, input bit tkh,
                         input logic [7:0] lo, input logic [7:0] hi,
                         output logic [7:0] nlo, output logic [7:0] nhi,
                         output bit o_main, output bit o_split);
    int v;
    nlo = lo; nhi = hi; o_main = 0; o_split = 0;
    case (md)
      2'd0: if (tk) begin
        v = int'(hi) * 32 + int'(lo[4:0]) + 1;
        o_main = (v == 8192);
        v = v % 8192;
        nhi = 8'(v / 32);
        nlo = {lo[7:5], 5'(v % 32)};
      end
      2'd1: if (tk) begin
        v = int'(hi) * 256 + int'(lo) + 1;
        o_main = (v == 65536);
        v = v % 65536;
        nhi = 8'(v / 256);
        nlo = 8'(v % 256);
      end
      2'd2: if (tk) begin
        if (lo == 8'hFF) begin nlo = hi; o_main = 1; end
        else nlo = 8'(int'(lo) + 1);
      end
      default: if (split_ok) begin
        if (tk)  begin o_main  = (lo == 8'hFF); nlo = 8'(int'(lo) + 1); end
        if (tkh) begin o_split = (hi == 8'hFF); nhi = 8'(int'(hi) + 1); end
      end
    endcase
  endtask

  task automatic cyc(input bit w, input logic [2:0] a, input logic [7:0] d, input bit mc,
                     input logic [1:0] ack = 2'b00, input logic [1:0] cnt = 2'b00,
                     input logic [1:0] gt = 2'b11);
    bit edge_i [2];
    bit tk [2];
    bit oa, ob, oc, ox;
    logic [7:0] nlo [2];
    logic [7:0] nhi [2];
    logic [1:0] set;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; mc_en = mc;
    irq_ack = ack; ext_cnt = cnt; ext_gate = gt;
    #1;
    for (int i = 0; i < 2; i++) begin
      logic [3:0] c;
      c = (i == 0) ? m_cfg[3:0] : m_cfg[7:4];
      edge_i[i] = mc && m_smp[i] && !cnt[i];
      tk[i] = m_run[i] && (!c[3] || gt[i]) && (c[2] ? edge_i[i] : mc);
    end
    advance(m_cfg[1:0], 1, tk[0], mc && m_run[1], m_lo[0], m_hi[0], nlo[0], nhi[0], oa, ob);
    advance(m_cfg[5:4], 0, tk[1], 0, m_lo[1], m_hi[1], nlo[1], nhi[1], oc, ox);
    last_rd = reg_rdata;
    check(tag_for(a), reg_rdata, exp_read(a));
    check("R9", {6'd0, ovf_flag}, {6'd0, m_flag});
    check("R7", {7'd0, t1_ovf_pulse}, {7'd0, oc});
    if (w) begin
      case (a)
        3'd2: nlo[0] = d;
        3'd3: nhi[0] = d;
        3'd4: nlo[1] = d;
        3'd5: nhi[1] = d;
        default: ;
      endcase
    end
    set[0] = oa;
    set[1] = (m_cfg[1:0] == 2'd3) ? ob : oc;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      if (set[i]) m_flag[i] = 1'b1;
      else if (ack[i]) m_flag[i] = 1'b0;
      else if (w && a == 3'd1) m_flag[i] = (i == 1) ? d[7] : d[5];
      if (mc) m_smp[i] = cnt[i];
      m_lo[i] = nlo[i];
      m_hi[i] = nhi[i];
    end
    if (w && a == 3'd1) m_run = {d[6], d[4]};
    if (w && a == 3'd0) m_cfg = d;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1, R11: reset contents
    for (int a = 0; a < 8; a++) begin
      cyc(0, 3'(a), 8'h00, 0);
      check("R1", last_rd, 8'h00);
    end

    // R4: 16-bit wrap FFFEh -> 0000h after two steps, flag set
    cyc(1, 3'd0, 8'h01, 0);
    cyc(1, 3'd2, 8'hFE, 0);
    cyc(1, 3'd3, 8'hFF, 0);
    cyc(1, 3'd1, 8'h10, 0);
    cyc(0, 3'd2, 8'h00, 1);
    cyc(0, 3'd2, 8'h00, 1);
    cyc(0, 3'd2, 8'h00, 0);
    check("R4", last_rd, 8'h00);
    check("R9", {7'd0, ovf_flag[0]}, 8'h01);

    // R9: acknowledge clears flag 0
    cyc(0, 3'd1, 8'h00, 0, 2'b01);
    cyc(0, 3'd1, 8'h00, 0);
    check("R9", last_rd, 8'h10);

    // R5: reload from high byte on wrap
    cyc(1, 3'd0, 8'h02, 0);
    cyc(1, 3'd3, 8'hA0, 0);
    cyc(1, 3'd2, 8'hFF, 0);
    cyc(0, 3'd2, 8'h00, 1);
    cyc(0, 3'd2, 8'h00, 0);
    check("R5", last_rd, 8'hA0);
    check("R5", {7'd0, ovf_flag[0]}, 8'h01);

    // R2: gate bit set and gate pin low blocks counting; pin high lets it through
    cyc(1, 3'd0, 8'h0A, 0, 2'b00, 2'b00, 2'b00);
    repeat (3) cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b00, 2'b00);
    cyc(0, 3'd2, 8'h00, 0, 2'b00, 2'b00, 2'b00);
    check("R2", last_rd, 8'hA0);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b00, 2'b01);
    cyc(0, 3'd2, 8'h00, 0);
    check("R2", last_rd, 8'hA1);

    // R10: write on a wrapping step: write lands, carry and flag still happen
    cyc(1, 3'd1, 8'h10, 0);
    cyc(1, 3'd0, 8'h01, 0);
    cyc(1, 3'd3, 8'hFF, 0);
    cyc(1, 3'd2, 8'hFF, 0);
    cyc(1, 3'd2, 8'h55, 1);
    cyc(0, 3'd2, 8'h00, 0);
    check("R10", last_rd, 8'h55);
    cyc(0, 3'd3, 8'h00, 0);
    check("R10", last_rd, 8'h00);
    check("R10", {7'd0, ovf_flag[0]}, 8'h01);

    // R7: counter 1 in layout 11 holds
    cyc(1, 3'd0, 8'h30, 0);
    cyc(1, 3'd1, 8'h50, 0);
    repeat (3) cyc(0, 3'd4, 8'h00, 1);
    cyc(0, 3'd4, 8'h00, 0);
    check("R7", last_rd, 8'h00);

    // R8: two falling edges on the count pin give two steps
    cyc(1, 3'd0, 8'h05, 0);
    cyc(1, 3'd2, 8'h00, 0);
    cyc(1, 3'd3, 8'h00, 0);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b01);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b01);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b00);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b00);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b01);
    cyc(0, 3'd2, 8'h00, 1, 2'b00, 2'b00);
    cyc(0, 3'd2, 8'h00, 0);
    check("R8", last_rd, 8'h02);

    // random traffic against the bench model (R3, R6 and all others)
    for (int n = 0; n < 6000; n++) begin
      bit w;
      logic [2:0] a;
      logic [7:0] d;
      w = (($urandom % 12) == 0);
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (w && a == 3'd0 && ($urandom % 2) == 0) d[1:0] = 2'd3;
      if (w && a == 3'd2 || w && a == 3'd4) d = 8'hF0 | d[3:0];
      cyc(w, a, d, ($urandom % 3) != 0,
          2'(($urandom % 24) == 0 ? $urandom : 0), 2'($urandom), 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule